// File: doc/BRIEF.md
# Mirror Signal Detector

This block watches the digitized RF amplitude coming off an optical disc pickup and decides, one sample at a time, whether the beam sits on a track or has drifted into the mirror-like land between tracks. Every accepted sample, marked by a valid strobe at roughly 1.4 MHz, updates two trackers. A peak tracker jumps up to any larger sample and otherwise sinks slowly towards the input. A bottom tracker drops at once to any smaller sample and otherwise climbs back towards the input at one of four selectable release rates. The difference between the two trackers is the RF envelope.

A first-order recursive average of the envelope sets a moving reference. A 2-bit sensitivity field scales that average to 3/8, 1/2, 5/8 or 3/4 to form the comparison threshold. A two-state machine raises the mirror bit when the envelope collapses below the threshold. It drops the bit only when the envelope has climbed back to at least the threshold plus a small hysteresis margin, so that noise near the threshold does not make the output chatter. Between strobes, nothing changes.

Top module: `mirdet_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the peak tracker to 0, the bottom tracker to all ones, the envelope average to 0 and the machine to TRACK, so mirror reads 0 after the edge. It remains 0 for any sample values until an envelope below a nonzero threshold is seen.
- R2: At a clock edge with smp_vld low, the peak, the bottom, the average and the machine state all keep their values, so mirror does not change.
- R3: At a strobe, a sample strictly above the held peak is loaded into the peak. Otherwise the peak becomes peak - ((peak - sample) >> 3).
- R4: At a strobe, a sample strictly below the held bottom is loaded into the bottom. Otherwise the bottom becomes bottom + ((sample - bottom) >> s), with s = 5, 4, 3, 2 for rel_sel = 0, 1, 2, 3. A larger code releases faster.
- R5: The envelope is peak - bottom when peak is greater than bottom, and 0 otherwise.
- R6: The average is kept as an accumulator acc of DW+6 bits, with avg = acc >> 6. At each strobe, acc becomes acc + env - avg.
- R7: The threshold is floor(avg * (3 + sens_sel) / 8). This gives 3/8, 1/2, 5/8 and 3/4 of the average for sens_sel = 0, 1, 2, 3.
- R8: Transition TRACK_TO_GAP: in state TRACK (mirror 0), a strobe with env < threshold moves the machine to GAP (mirror 1).
- R9: Transition GAP_TO_TRACK: in state GAP, a strobe with env >= threshold + 2 returns the machine to TRACK. A strobe with an envelope between these two limits leaves the state unchanged.
- R10: At each strobe, the decision uses the envelope and threshold held before that strobe. The new mirror value appears right after the clock edge that accepts the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample valid strobe, one sample per high cycle |
| smp_data | input | DW | Unsigned RF amplitude sample |
| rel_sel | input | 2 | Bottom tracker release speed code |
| sens_sel | input | 2 | Threshold sensitivity code |
| mirror | output | 1 | 1 when the beam is between tracks (state GAP) |

## Verification
The bench builds the block with its default parameters: 8-bit samples, an average shift of 6, a peak decay shift of 3, a slowest release shift of 5, and a hysteresis of 2. These values are small enough that full-scale swings, flat stretches and the startup case where the peak lies below the bottom can all be reached within a few hundred strobes. They also let the envelope fall through the threshold and recover for every pairing of release and sensitivity codes. Sparse strobes, strobe-free idle stretches and a mid-run reset exercise the hold and timing rules.

// File: rtl/mirdet_pkg.sv
package mirdet_pkg;

    typedef enum logic {
        MD_TRACK = 1'b0,
        MD_GAP   = 1'b1
    } md_state_e;

endpackage

// File: rtl/mirdet_hold.sv
module mirdet_hold #(
    parameter int DW      = 8,
    parameter int SW      = 4,
    parameter bit IS_PEAK = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [DW-1:0] sample,
    input  logic [SW-1:0] shift,
    output logic [DW-1:0] hold
);

    logic [DW-1:0] hold_n;
    logic [DW-1:0] gap;

    generate
        if (IS_PEAK) begin : g_peak
            always_comb begin
                gap = hold - sample;
                if (sample > hold) hold_n = sample;
                else               hold_n = hold - (gap >> shift);
            end
            always_ff @(posedge clk) begin
                if (rst)      hold <= '0;
                else if (stb) hold <= hold_n;
            end
        end else begin : g_bottom
            always_comb begin
                gap = sample - hold;
                if (sample < hold) hold_n = sample;
                else               hold_n = hold + (gap >> shift);
            end
            always_ff @(posedge clk) begin
                if (rst)      hold <= '1;
                else if (stb) hold <= hold_n;
            end
        end
    endgenerate

endmodule

// File: rtl/mirdet_avg.sv
module mirdet_avg #(
    parameter int DW        = 8,
    parameter int AVG_K     = 6,
    parameter int SENS_W    = 2,
    parameter int SENS_BASE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [DW-1:0]     env,
    input  logic [SENS_W-1:0] sens,
    output logic [DW-1:0]     thr
);

    localparam int AW = DW + AVG_K;
    localparam int MW = DW + 3;

    logic [AW-1:0] acc;
    logic [DW-1:0] avg;
    logic [AW:0]   acc_n;
    logic [MW-1:0] prod;
    logic [3:0]    num;

    always_comb begin
        avg   = acc[AW-1:AVG_K];
        acc_n = {1'b0, acc} + (AW+1)'(env) - (AW+1)'(avg);
        num   = 4'(SENS_BASE) + 4'(sens);
        prod  = MW'(avg) * MW'(num);
        thr   = prod[MW-1:3];
    end

    always_ff @(posedge clk) begin
        if (rst)      acc <= '0;
        else if (stb) acc <= acc_n[AW-1:0];
    end

endmodule

// File: rtl/mirdet_fsm.sv
module mirdet_fsm
    import mirdet_pkg::*;
#(
    parameter int DW   = 8,
    parameter int HYST = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [DW-1:0] env,
    input  logic [DW-1:0] thr,
    output logic          mirror
);

    md_state_e     state;
    md_state_e     state_n;
    logic [DW:0]   thr_hi;

    always_comb begin
        thr_hi  = {1'b0, thr} + (DW+1)'(HYST);
        state_n = state;
        unique case (state)
            MD_TRACK: if (stb && env < thr)               state_n = MD_GAP;
            MD_GAP:   if (stb && {1'b0, env} >= thr_hi)   state_n = MD_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= MD_TRACK;
        else     state <= state_n;
    end

    always_comb begin
        mirror = (state == MD_GAP);
    end

endmodule

// File: rtl/mirdet_top.sv
module mirdet_top #(
    parameter int DW         = 8,
    parameter int AVG_K      = 6,
    parameter int PEAK_SHIFT = 3,
    parameter int BOT_SLOW   = 5,
    parameter int HYST       = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    input  logic [1:0]    rel_sel,
    input  logic [1:0]    sens_sel,
    output logic          mirror
);

    localparam int SW = $clog2(DW + 1) + 1;

    logic [DW-1:0] peak;
    logic [DW-1:0] bottom;
    logic [DW-1:0] env;
    logic [DW-1:0] thr;
    logic [SW-1:0] bot_shift;

    assign bot_shift = SW'(BOT_SLOW) - SW'(rel_sel);
    assign env       = (peak > bottom) ? (peak - bottom) : '0;

    mirdet_hold #(.DW(DW), .SW(SW), .IS_PEAK(1'b1)) u_peak (
        .clk(clk), .rst(rst), .stb(smp_vld), .sample(smp_data),
        .shift(SW'(PEAK_SHIFT)), .hold(peak)
    );

    mirdet_hold #(.DW(DW), .SW(SW), .IS_PEAK(1'b0)) u_bottom (
        .clk(clk), .rst(rst), .stb(smp_vld), .sample(smp_data),
        .shift(bot_shift), .hold(bottom)
    );

    mirdet_avg #(.DW(DW), .AVG_K(AVG_K), .SENS_W(2), .SENS_BASE(3)) u_avg (
        .clk(clk), .rst(rst), .stb(smp_vld), .env(env),
        .sens(sens_sel), .thr(thr)
    );

    mirdet_fsm #(.DW(DW), .HYST(HYST)) u_fsm (
        .clk(clk), .rst(rst), .stb(smp_vld), .env(env),
        .thr(thr), .mirror(mirror)
    );

endmodule

module mirdet_chk #(
    parameter int DW   = 8,
    parameter int HYST = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          stb,
    input logic [DW-1:0] sample,
    input logic [DW-1:0] peak,
    input logic [DW-1:0] bottom,
    input logic [DW-1:0] env,
    input logic [DW-1:0] thr,
    input logic          mirror
);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(mirror) && $stable(peak) && $stable(bottom)));

    assert_peak_load_R3: assert property (@(posedge clk) disable iff (rst)
        (stb && sample > peak) |=> (peak == $past(sample)));

    assert_peak_decay_R3: assert property (@(posedge clk) disable iff (rst)
        (stb && sample <= peak) |=> (peak <= $past(peak) && peak >= $past(sample)));

    assert_bottom_load_R4: assert property (@(posedge clk) disable iff (rst)
        (stb && sample < bottom) |=> (bottom == $past(sample)));

    assert_bottom_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (stb && sample >= bottom) |=> (bottom >= $past(bottom) && bottom <= $past(sample)));

    assert_rise_cond_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mirror) |-> $past(stb && env < thr));

    assert_fall_cond_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(mirror) |-> $past(stb && ({1'b0, env} >= ({1'b0, thr} + (DW+1)'(HYST)))));

endmodule

bind mirdet_top mirdet_chk #(.DW(DW), .HYST(HYST)) u_chk (
    .clk(clk), .rst(rst), .stb(smp_vld), .sample(smp_data),
    .peak(peak), .bottom(bottom), .env(env), .thr(thr), .mirror(mirror)
);

// File: tb/mirdet_top_test.sv
`timescale 1ns/1ps
module mirdet_top_test;

    localparam int DW = 8;
    localparam int MAXV = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_data = '0;
    logic [1:0] rel_sel = '0;
    logic [1:0] sens_sel = '0;
    logic       mirror;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    int m_peak, m_bot, m_acc, m_state;

    always #2.5 clk = ~clk;

    mirdet_top #(.DW(DW), .AVG_K(6), .PEAK_SHIFT(3), .BOT_SLOW(5), .HYST(2)) uut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .rel_sel(rel_sel), .sens_sel(sens_sel), .mirror(mirror)
    );

    task automatic model_edge(input bit r, input bit v, input int s, input int rl, input int sn);
        int env, avg, thr;
        if (r) begin
            m_peak = 0; m_bot = MAXV; m_acc = 0; m_state = 0;
        end else if (v) begin
            env = (m_peak > m_bot) ? m_peak - m_bot : 0;
            avg = m_acc / 64;
            thr = (avg * (3 + sn)) / 8;
            if (m_state == 0 && env < thr)           m_state = 1;
            else if (m_state == 1 && env >= thr + 2) m_state = 0;
            m_acc = m_acc + env - avg;
            if (s > m_peak) m_peak = s;
            else            m_peak = m_peak - ((m_peak - s) / 8);
            if (s < m_bot)  m_bot = s;
            else            m_bot = m_bot + ((s - m_bot) / (1 << (5 - rl)));
        end
    endtask

    task automatic compare(input string tag);
        compared++;
        if (mirror !== m_state[0]) begin
            mismatched++;
            $display("FAIL %s mirror actual=%0b expected=%0d at %0t", tag, mirror, m_state, $time);
        end
    endtask

    task automatic cyc(input bit r, input bit v, input int s, input int rl, input int sn, input string tag);
        @(negedge clk);
        compare(tag);
        rst = r; smp_vld = v; smp_data = 8'(s); rel_sel = 2'(rl); sens_sel = 2'(sn);
        model_edge(r, v, s, rl, sn);
    endtask

    function automatic int clip(input int x);
        if (x < 0) return 0;
        if (x > MAXV) return MAXV;
        return x;
    endfunction

    // pattern: 0 idle, 1 wide swing, 2 flat, 3 random, 4 sparse random
    task automatic run(input int n, input int pat, input int rl, input int sn, input string tag);
        for (int i = 0; i < n; i++) begin
            int s;
            bit v;
            v = 1'b1;
            unique case (pat)
                0: begin v = 1'b0; s = int'($urandom_range(0, MAXV)); end
                1: s = clip(((i % 2) != 0 ? 225 : 25) + int'($urandom_range(0, 12)) - 6);
                2: s = clip(128 + int'($urandom_range(0, 4)) - 2);
                3: s = int'($urandom_range(0, MAXV));
                default: begin v = ($urandom_range(0, 3) == 0); s = int'($urandom_range(0, MAXV)); end
            endcase
            cyc(1'b0, v, s, rl, sn, tag);
        end
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        m_peak = 0; m_bot = MAXV; m_acc = 0; m_state = 0;
        @(negedge clk);
        rst = 1'b1;
        model_edge(1'b1, 1'b0, 0, 0, 0);
        cyc(1'b1, 1'b0, 0, 0, 0, "R1 reset");
        cyc(1'b0, 1'b0, 0, 0, 0, "R1 reset");
        // R1: startup clamp, mirror must stay low while peak<bottom
        run(40, 3, 1, 2, "R5 startup clamp");
        // R2: idle with strobe low
        run(60, 0, 2, 3, "R2 idle");
        for (int rl = 0; rl < 4; rl++) begin
            for (int sn = 0; sn < 4; sn++) begin
                run(250, 1, rl, sn, "R3 R6 R7 swing");
                run(300, 2, rl, sn, "R4 R8 flat");
                run(30, 0, rl, sn, "R2 idle in gap");
                run(250, 1, rl, sn, "R9 recover");
            end
        end
        // mid-run reset
        cyc(1'b1, 1'b1, 200, 1, 1, "R1 mid reset");
        cyc(1'b1, 1'b0, 0, 1, 1, "R1 mid reset");
        run(20, 3, 3, 0, "R1 after reset");
        for (int k = 0; k < 8; k++) begin
            run(200, 4, k % 4, (k + 1) % 4, "R10 sparse");
            run(200, 2, k % 4, k % 4, "R8 R10 sparse flat");
            run(150, 1, (k + 2) % 4, k % 4, "R9 R10 swing");
        end
        run(2000, 3, 2, 1, "R10 random");
        @(negedge clk);
        compare("R10 final");
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule